// File: doc/BRIEF.md
# Blocking Word Handshake Channel

This block moves single data words from a producing controller to a consuming controller over a valid/ready link. The link carries one word at a time. Each side is a small sequencer that starts when it gets a one-cycle request, stays busy until the handshake completes, and then gives a one-cycle done pulse.

When the producer gets a send request, it places the word on the link and raises valid in the same step. It holds both until it samples ready high. It then drops valid and returns the data bus to zero. When the consumer gets a receive request, it raises ready and waits for valid. On the edge where it samples valid, it stores the bus into its output register and drops ready.

Each word goes through a full handshake before the next one can start, so the channel is never an elastic pipeline. The data bus reads zero whenever no word is being offered.

Top module: `hs_channel`

## Requirements
- R1: While reset is asserted, and straight after it, link_valid, link_ready, link_data, rcv_word, snd_busy, rcv_busy, snd_done and rcv_done are all 0.
- R2: A send request sampled while the sender is idle makes link_valid 1, link_data equal to snd_word and snd_busy 1 in the next cycle.
- R3: While link_valid is 1 and link_ready has not been sampled high, link_valid stays 1 and link_data does not change.
- R4: On the edge where the sender samples link_ready high, link_valid and link_data go to 0 and snd_done is 1 for exactly one cycle. link_data is 0 whenever link_valid is 0.
- R5: A receive request sampled while the receiver is idle makes link_ready 1 and rcv_busy 1 in the next cycle.
- R6: While link_ready is 1 and link_valid has not been sampled high, link_ready stays 1.
- R7: On the edge where the receiver samples link_valid high, rcv_word takes the value of link_data, link_ready goes to 0 and rcv_done is 1 for exactly one cycle.
- R8: A send request that arrives while the sender is busy is ignored, and the word already on link_data is kept.
- R9: rcv_word holds the last captured word until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snd_req | input | 1 | Start a send (one-cycle request) |
| snd_word | input | DATA_W | Word to send, sampled together with snd_req |
| snd_busy | output | 1 | Sender is waiting for ready |
| snd_done | output | 1 | One-cycle pulse when the send completes |
| rcv_req | input | 1 | Start a receive (one-cycle request) |
| rcv_busy | output | 1 | Receiver is waiting for valid |
| rcv_done | output | 1 | One-cycle pulse when the receive completes |
| rcv_word | output | DATA_W | Last captured word |
| link_valid | output | 1 | Valid line of the link |
| link_ready | output | 1 | Ready line of the link |
| link_data | output | DATA_W | Data bus of the link, 0 when idle |

## Verification
If either sequencer is in the wrong state, the error shows at the link within one cycle. Valid or ready stays high past the completing edge, drops too early, or a done pulse appears without its partner. A capture from the wrong cycle shows up as a wrong rcv_word at the next sample point. A sender that accepts a request while busy shows up as a changed link_data word during the wait. Both request orders are exercised, as are requests in the same cycle and several wait lengths, so that every state pairing is visited.

// File: rtl/hs_chan_pkg.sv
package hs_chan_pkg;
  typedef enum logic {
    SND_IDLE = 1'b0,
    SND_WAIT = 1'b1
  } snd_state_t;

  typedef enum logic {
    RCV_IDLE = 1'b0,
    RCV_WAIT = 1'b1
  } rcv_state_t;
endpackage

// File: rtl/hs_sender.sv
module hs_sender
  import hs_chan_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o,
  output logic              done_o
);
  snd_state_t        state_q, state_d;
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;
  logic              done_q, done_d;

  always_comb begin
    state_d = state_q;
    valid_d = valid_q;
    data_d  = data_q;
    data_en = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      SND_IDLE: begin
        if (req_i) begin
          state_d = SND_WAIT;
          valid_d = 1'b1;
          data_d  = word_i;
          data_en = 1'b1;
        end
      end
      SND_WAIT: begin
        if (ready_i) begin
          state_d = SND_IDLE;
          valid_d = 1'b0;
          data_d  = '0;
          data_en = 1'b1;
          done_d  = 1'b1;
        end
      end
      default: state_d = SND_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SND_IDLE;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign busy_o  = (state_q == SND_WAIT);
  assign done_o  = done_q;

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o))); // R3
  AST_SEND_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i) |=> (!valid_o && data_o == '0 && done_o)); // R4
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (data_o == '0)); // R4
  AST_SEND_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R4
  AST_SEND_START: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !busy_o) |=> (valid_o && data_o == $past(word_i))); // R2
endmodule

// File: rtl/hs_receiver.sv
module hs_receiver
  import hs_chan_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] word_o,
  output logic              busy_o,
  output logic              done_o
);
  rcv_state_t        state_q, state_d;
  logic              ready_q, ready_d;
  logic [DATA_W-1:0] word_q;
  logic              word_en;
  logic              done_q, done_d;

  always_comb begin
    state_d = state_q;
    ready_d = ready_q;
    word_en = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      RCV_IDLE: begin
        if (req_i) begin
          state_d = RCV_WAIT;
          ready_d = 1'b1;
        end
      end
      RCV_WAIT: begin
        if (valid_i) begin
          state_d = RCV_IDLE;
          ready_d = 1'b0;
          word_en = 1'b1;
          done_d  = 1'b1;
        end
      end
      default: state_d = RCV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RCV_IDLE;
      ready_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= ready_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= data_i;
    end
  end

  assign ready_o = ready_q;
  assign word_o  = word_q;
  assign busy_o  = (state_q == RCV_WAIT);
  assign done_o  = done_q;

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !valid_i) |=> ready_o); // R6
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && valid_i) |=> (!ready_o && done_o && word_o == $past(data_i))); // R7
  AST_WORD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready_o && valid_i) |=> $stable(word_o)); // R9
  AST_RCV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_RCV_START: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !busy_o) |=> ready_o); // R5
endmodule

// File: rtl/hs_channel.sv
module hs_channel #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snd_req,
  input  logic [DATA_W-1:0] snd_word,
  output logic              snd_busy,
  output logic              snd_done,
  input  logic              rcv_req,
  output logic              rcv_busy,
  output logic              rcv_done,
  output logic [DATA_W-1:0] rcv_word,
  output logic              link_valid,
  output logic              link_ready,
  output logic [DATA_W-1:0] link_data
);
  logic              valid_w;
  logic              ready_w;
  logic [DATA_W-1:0] data_w;

  hs_sender #(.DATA_W(DATA_W)) u_snd (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (snd_req),
    .word_i  (snd_word),
    .ready_i (ready_w),
    .valid_o (valid_w),
    .data_o  (data_w),
    .busy_o  (snd_busy),
    .done_o  (snd_done)
  );

  hs_receiver #(.DATA_W(DATA_W)) u_rcv (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (rcv_req),
    .valid_i (valid_w),
    .data_i  (data_w),
    .ready_o (ready_w),
    .word_o  (rcv_word),
    .busy_o  (rcv_busy),
    .done_o  (rcv_done)
  );

  assign link_valid = valid_w;
  assign link_ready = ready_w;
  assign link_data  = data_w;

  AST_DONE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    snd_done == rcv_done); // R4
  AST_ONE_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_busy && !snd_done) |=> (snd_busy || snd_done)); // R8
endmodule

// File: tb/hs_channel_bench.sv
module hs_channel_bench;
  localparam int DW = 16;
  localparam int NV = 6;
  // vector: {send_first, probe, gap[7:0], word[DW-1:0]}
  localparam logic [DW+9:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'd0, 16'hA5C3},
    {1'b1, 1'b1, 8'd3, 16'h1234},
    {1'b0, 1'b0, 8'd2, 16'hFFFF},
    {1'b0, 1'b1, 8'd4, 16'h0F0F},
    {1'b1, 1'b0, 8'd1, 16'h8001},
    {1'b0, 1'b0, 8'd1, 16'h7E7E}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          snd_req, rcv_req;
  logic [DW-1:0] snd_word;
  logic          snd_busy, snd_done, rcv_busy, rcv_done;
  logic [DW-1:0] rcv_word, link_data;
  logic          link_valid, link_ready;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] last_word;

  always #2 clk = ~clk;

  hs_channel #(.DATA_W(DW)) u_hs_channel (
    .clk(clk), .rst_n(rst_n),
    .snd_req(snd_req), .snd_word(snd_word), .snd_busy(snd_busy), .snd_done(snd_done),
    .rcv_req(rcv_req), .rcv_busy(rcv_busy), .rcv_done(rcv_done), .rcv_word(rcv_word),
    .link_valid(link_valid), .link_ready(link_ready), .link_data(link_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic completion(input logic [DW-1:0] w);
    @(negedge clk);
    check("R4 valid cleared", {31'd0, link_valid}, 0);
    check("R4 bus zero", {16'd0, link_data}, 0);
    check("R7 ready cleared", {31'd0, link_ready}, 0);
    check("R7 captured word", {16'd0, rcv_word}, {16'd0, w});
    check("R4 send done", {31'd0, snd_done}, 1);
    check("R7 receive done", {31'd0, rcv_done}, 1);
    @(negedge clk);
    check("R4 send done one cycle", {31'd0, snd_done}, 0);
    check("R7 receive done one cycle", {31'd0, rcv_done}, 0);
    check("R4 sender idle", {31'd0, snd_busy}, 0);
    check("R9 word held", {16'd0, rcv_word}, {16'd0, w});
    last_word = w;
  endtask

  task automatic xfer(input logic sfirst, input logic probe, input int gap, input logic [DW-1:0] w);
    @(negedge clk);
    if (sfirst) begin
      snd_req = 1'b1; snd_word = w;
      if (gap == 0) rcv_req = 1'b1;
      @(negedge clk);
      snd_req = 1'b0; rcv_req = 1'b0;
      check("R2 valid", {31'd0, link_valid}, 1);
      check("R2 data", {16'd0, link_data}, {16'd0, w});
      check("R2 busy", {31'd0, snd_busy}, 1);
      if (gap == 0) check("R5 ready", {31'd0, link_ready}, 1);
      for (int i = 0; i < gap; i++) begin
        if (probe && i == 0) begin snd_req = 1'b1; snd_word = ~w; end
        @(negedge clk);
        snd_req = 1'b0;
        check("R3 valid held", {31'd0, link_valid}, 1);
        check(probe ? "R8 busy request ignored" : "R3 data held", {16'd0, link_data}, {16'd0, w});
      end
      if (gap > 0) begin
        rcv_req = 1'b1;
        @(negedge clk);
        rcv_req = 1'b0;
        check("R5 ready", {31'd0, link_ready}, 1);
        check("R5 busy", {31'd0, rcv_busy}, 1);
        check("R3 valid held", {31'd0, link_valid}, 1);
      end
    end else begin
      rcv_req = 1'b1;
      @(negedge clk);
      rcv_req = 1'b0;
      check("R5 ready", {31'd0, link_ready}, 1);
      check("R5 busy", {31'd0, rcv_busy}, 1);
      for (int i = 0; i < gap; i++) begin
        if (probe && i == 0) rcv_req = 1'b1;
        @(negedge clk);
        rcv_req = 1'b0;
        check("R6 ready held", {31'd0, link_ready}, 1);
        check("R9 word held", {16'd0, rcv_word}, {16'd0, last_word});
      end
      snd_req = 1'b1; snd_word = w;
      @(negedge clk);
      snd_req = 1'b0;
      check("R2 valid", {31'd0, link_valid}, 1);
      check("R2 data", {16'd0, link_data}, {16'd0, w});
      check("R6 ready held", {31'd0, link_ready}, 1);
    end
    completion(w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; snd_req = 1'b0; rcv_req = 1'b0; snd_word = '0;
    last_word = '0;
    #1;
    check("R1 valid in reset", {31'd0, link_valid}, 0);
    check("R1 ready in reset", {31'd0, link_ready}, 0);
    check("R1 bus in reset", {16'd0, link_data}, 0);
    check("R1 word in reset", {16'd0, rcv_word}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", {30'd0, snd_busy, rcv_busy}, 0);
    check("R1 done after reset", {30'd0, snd_done, rcv_done}, 0);

    for (int k = 0; k < NV; k++) begin
      xfer(VEC[k][DW+9], VEC[k][DW+8], int'(VEC[k][DW+7:DW]), VEC[k][DW-1:0]);
    end

    // Reset while both sides are busy
    @(negedge clk);
    snd_req = 1'b1; snd_word = 16'hBEEF;
    @(negedge clk);
    snd_req = 1'b0; rcv_req = 1'b1;
    @(negedge clk);
    rcv_req = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 valid cleared by reset", {31'd0, link_valid}, 0);
    check("R1 ready cleared by reset", {31'd0, link_ready}, 0);
    check("R1 bus cleared by reset", {16'd0, link_data}, 0);
    check("R1 word cleared by reset", {16'd0, rcv_word}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    last_word = '0;
    @(negedge clk);
    check("R1 idle after reset", {28'd0, snd_busy, rcv_busy, snd_done, rcv_done}, 0);

    // Back-to-back transfers after reset
    xfer(1'b1, 1'b0, 0, 16'h0001);
    xfer(1'b0, 1'b0, 0, 16'h0000);
    finish_run();
  end
endmodule